// File: doc/BRIEF.md
# Constant-On-Time Buck Gate Sequencer

This block is the clocked timing core of a synchronous buck converter that runs on constant on-time. It has no free-running switching clock. A switching cycle begins only when three things hold together: the feedback comparator reports that the output is below target, the minimum off-time of the previous cycle has run out, and the valley current comparator reports that the low-side current is under its limit. Each cycle turns on the high-side switch for a count of clock cycles. That count is loaded from an input bus, which a separate block computes from the input and output voltages. The block then hands over to the low-side switch. A settable dead time keeps the two switches apart on every hand-over.

At light load, diode emulation can be selected. In that mode the low-side switch opens as soon as the zero-crossing comparator fires, so the switching rate falls while the on-time stays the same. Two fault inputs override normal operation. An overvoltage condition forces the low side on and the high side off. An undervoltage condition forces both gates off. When the enable input is low, both gates stay off and every internal timer is cleared.

Top module: `cot_gate_seq`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both high in the same clock cycle.
- R2: Each time `hs_gate` rises, `ls_gate` has been low for at least DEAD_CYC cycles. Each time `ls_gate` rises, `hs_gate` has been low for at least DEAD_CYC cycles.
- R3: A cycle starts at a clock edge where `enable`=1, `fb_low`=1, `ilim_over`=0 and no fault is present, with the block idle or the low side on and the minimum off-time expired. `hs_gate` then rises DEAD_CYC+1 cycles later and never earlier. With `fb_low`=0 no cycle starts.
- R4: `hs_gate` stays high for exactly N cycles. N is the value of `ton_count` at the edge where the cycle started, and a value of 0 counts as 1. Later changes to `ton_count` do not alter a pulse already in progress.
- R5: Between the fall of `hs_gate` and its next rise there are at least MINOFF_CYC cycles, unless `enable` went low in between.
- R6: While `ilim_over`=1, no cycle starts, even if `fb_low`=1. Once `ilim_over` returns to 0 and the other conditions hold, `hs_gate` rises DEAD_CYC+1 cycles later.
- R7: With `dem_en`=1, a `zero_cross`=1 at an edge while the low side is on (and no start is due) turns `ls_gate` off on that edge. With `dem_en`=0, `zero_cross` is ignored and `ls_gate` stays on.
- R8: While `ovp_active`=1 and `enable`=1, `hs_gate` is low from the next cycle on. `ls_gate` is high from DEAD_CYC+1 cycles after the assertion, or at once if it was already on, and stays high.
- R9: While `uvp_fault`=1 with `ovp_active`=0 and `enable`=1, both gates are low from the next cycle on. If both faults are present, the overvoltage behaviour of R8 takes priority.
- R10: `enable`=0 drives both gates low from the next cycle and clears all timers. After `enable` returns to 1 with `fb_low`=1, `hs_gate` rises DEAD_CYC+1 cycles later, whatever the previous off-time.
- R11: While `rst` is high, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; low holds both gates off and clears timers |
| fb_low | input | 1 | Feedback comparator: output below reference |
| ilim_over | input | 1 | Valley current comparator: low-side current above limit |
| zero_cross | input | 1 | Inductor current zero-crossing comparator |
| ovp_active | input | 1 | Overvoltage protection latched |
| uvp_fault | input | 1 | Undervoltage fault latched |
| dem_en | input | 1 | 1 selects diode emulation, 0 selects forced continuous conduction |
| ton_count | input | TON_W | On-time length in clock cycles, taken at cycle start |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
Every gate output is a direct decode of the phase register. Fault and enable responses therefore appear one cycle after the input is applied. A cycle start shows on `hs_gate` DEAD_CYC+1 cycles after the qualifying edge, and an overvoltage clamp turns `ls_gate` on DEAD_CYC+1 cycles after assertion. The bench drives inputs on the falling edge and samples on later falling edges at exactly these counts. For each directed case it checks both the cycle before and the cycle of the expected change. For pulse width, the bench monitor keeps a history of `ton_count` values indexed by clock edge and compares each pulse against the value present at its start edge, DEAD_CYC+1 edges before the rise. Pulses cut short by a fault or by enable are excluded from the width check.

// File: rtl/cot_seq_pkg.sv
`timescale 1ns/1ps
package cot_seq_pkg;

    // Phases of the switching sequence; gates are a pure decode of these.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // both switches open
        PH_GAP_HI = 3'd1,  // dead time ahead of high side
        PH_HIGH   = 3'd2,  // on-time one-shot running
        PH_GAP_LO = 3'd3,  // dead time ahead of low side
        PH_LOW    = 3'd4,  // synchronous rectifier conducting
        PH_CLAMP  = 3'd5   // overvoltage clamp, low side held
    } phase_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    function automatic gate_pair_t decode_gates(phase_t ph);
        gate_pair_t g;
        g.hs = (ph == PH_HIGH);
        g.ls = (ph == PH_LOW) || (ph == PH_CLAMP);
        return g;
    endfunction

    // Bits needed to hold a down-count that starts at n-1.
    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cot_oneshot.sv
`timescale 1ns/1ps
module cot_oneshot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cot_cycle_gate.sv
`timescale 1ns/1ps
module cot_cycle_gate #(
    parameter int TON_W = 8
) (
    input  logic             fb_low,
    input  logic             ilim_over,
    input  logic             offtime_done,
    input  logic [TON_W-1:0] ton_in,
    output logic             start_ok,
    output logic [TON_W-1:0] on_load_val
);
    // A new on-pulse needs demand, an expired off-time and a valley current under limit.
    assign start_ok = fb_low && offtime_done && !ilim_over;

    // The one-shot runs load_val+1 cycles; a zero request still yields one cycle.
    assign on_load_val = (ton_in == '0) ? '0 : (ton_in - 1'b1);
endmodule

// File: rtl/cot_phase_fsm.sv
`timescale 1ns/1ps
module cot_phase_fsm
    import cot_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   ovp_active,
    input  logic   uvp_fault,
    input  logic   dem_en,
    input  logic   zero_cross,
    input  logic   start_ok,
    input  logic   dt_done,
    input  logic   on_done,
    output phase_t phase,
    output logic   load_dt,
    output logic   load_on,
    output logic   load_off
);
    phase_t nxt;

    always_comb begin
        nxt = phase;
        if (!enable) begin
            nxt = PH_IDLE;
        end else if (ovp_active) begin
            case (phase)
                PH_IDLE, PH_GAP_HI, PH_HIGH: nxt = PH_GAP_LO;
                PH_GAP_LO:                   nxt = dt_done ? PH_CLAMP : PH_GAP_LO;
                PH_LOW, PH_CLAMP:            nxt = PH_CLAMP;
                default:                     nxt = PH_IDLE;
            endcase
        end else if (uvp_fault) begin
            nxt = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   if (start_ok) nxt = PH_GAP_HI;
                PH_GAP_HI: if (dt_done)  nxt = PH_HIGH;
                PH_HIGH:   if (on_done)  nxt = PH_GAP_LO;
                PH_GAP_LO: if (dt_done)  nxt = PH_LOW;
                PH_LOW: begin
                    if (start_ok)                  nxt = PH_GAP_HI;
                    else if (dem_en && zero_cross) nxt = PH_IDLE;
                end
                PH_CLAMP:  nxt = PH_LOW;
                default:   nxt = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        load_dt  = ((nxt == PH_GAP_HI) || (nxt == PH_GAP_LO)) && (nxt != phase);
        load_on  = (nxt == PH_GAP_HI) && (phase != PH_GAP_HI);
        load_off = (phase == PH_HIGH) && (nxt != PH_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/cot_gate_seq.sv
`timescale 1ns/1ps
module cot_gate_seq
    import cot_seq_pkg::*;
#(
    parameter int TON_W      = 8,
    parameter int DEAD_CYC   = 4,
    parameter int MINOFF_CYC = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fb_low,
    input  logic             ilim_over,
    input  logic             zero_cross,
    input  logic             ovp_active,
    input  logic             uvp_fault,
    input  logic             dem_en,
    input  logic [TON_W-1:0] ton_count,
    output logic             hs_gate,
    output logic             ls_gate
);
    localparam int DT_W  = cnt_width(DEAD_CYC);
    localparam int OFF_W = cnt_width(MINOFF_CYC);

    phase_t           phase;
    gate_pair_t       gates;
    logic             start_ok, dt_done, on_done, off_done;
    logic             load_dt, load_on, load_off;
    logic [TON_W-1:0] on_load_val;
    logic             timers_clr;

    assign timers_clr = !enable;

    cot_cycle_gate #(.TON_W(TON_W)) u_gate (
        .fb_low       (fb_low),
        .ilim_over    (ilim_over),
        .offtime_done (off_done),
        .ton_in       (ton_count),
        .start_ok     (start_ok),
        .on_load_val  (on_load_val)
    );

    cot_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .ovp_active (ovp_active),
        .uvp_fault  (uvp_fault),
        .dem_en     (dem_en),
        .zero_cross (zero_cross),
        .start_ok   (start_ok),
        .dt_done    (dt_done),
        .on_done    (on_done),
        .phase      (phase),
        .load_dt    (load_dt),
        .load_on    (load_on),
        .load_off   (load_off)
    );

    // Dead-time timer, shared by both hand-over directions.
    cot_oneshot #(.W(DT_W)) u_dead (
        .clk      (clk),
        .rst      (rst),
        .clr      (timers_clr),
        .load     (load_dt),
        .load_val (DT_W'(DEAD_CYC - 1)),
        .run      (1'b1),
        .expired  (dt_done)
    );

    // On-time one-shot: armed at cycle start, counts only while the high side conducts.
    cot_oneshot #(.W(TON_W)) u_on (
        .clk      (clk),
        .rst      (rst),
        .clr      (timers_clr),
        .load     (load_on),
        .load_val (on_load_val),
        .run      (phase == PH_HIGH),
        .expired  (on_done)
    );

    // Minimum off-time one-shot: armed whenever the high side turns off.
    cot_oneshot #(.W(OFF_W)) u_off (
        .clk      (clk),
        .rst      (rst),
        .clr      (timers_clr),
        .load     (load_off),
        .load_val (OFF_W'(MINOFF_CYC - 1)),
        .run      (1'b1),
        .expired  (off_done)
    );

    assign gates   = decode_gates(phase);
    assign hs_gate = gates.hs;
    assign ls_gate = gates.ls;
endmodule

// File: rtl/cot_gate_seq_checker.sv
`timescale 1ns/1ps
module cot_gate_seq_checker #(
    parameter int DEAD_CYC   = 4,
    parameter int MINOFF_CYC = 40
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic ovp_active,
    input logic uvp_fault,
    input logic dem_en,
    input logic zero_cross,
    input logic hs_gate,
    input logic ls_gate
);
    logic [15:0] hs_low_run;
    logic [15:0] ls_low_run;
    logic        en_dropped;
    logic        ovp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_low_run <= '1;
            ls_low_run <= '1;
            en_dropped <= 1'b0;
            ovp_q      <= 1'b0;
        end else begin
            hs_low_run <= hs_gate ? '0 : ((hs_low_run == 16'hFFFF) ? hs_low_run : hs_low_run + 1'b1);
            ls_low_run <= ls_gate ? '0 : ((ls_low_run == 16'hFFFF) ? ls_low_run : ls_low_run + 1'b1);
            en_dropped <= !enable ? 1'b1 : (hs_gate ? 1'b0 : en_dropped);
            ovp_q      <= ovp_active;
        end
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

    a_r2_dead_before_high: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate) |-> (int'(ls_low_run) >= DEAD_CYC));

    a_r2_dead_before_low: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_gate) |-> (int'(hs_low_run) >= DEAD_CYC));

    a_r5_min_off: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate) |-> (en_dropped || (int'(hs_low_run) >= MINOFF_CYC)));

    a_r7_zero_cross_cut: assert property (@(posedge clk) disable iff (rst)
        (enable && !ovp_active && !uvp_fault && !ovp_q && dem_en && zero_cross && ls_gate)
        |=> !ls_gate);

    a_r8_ovp_high_off: assert property (@(posedge clk) disable iff (rst)
        (enable && ovp_active) |=> !hs_gate);

    a_r9_uvp_all_off: assert property (@(posedge clk) disable iff (rst)
        (enable && !ovp_active && uvp_fault) |=> (!hs_gate && !ls_gate));

    a_r10_disable_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!hs_gate && !ls_gate));

    a_r11_reset_off: assert property (@(posedge clk)
        rst |=> (!hs_gate && !ls_gate));
endmodule

bind cot_gate_seq cot_gate_seq_checker #(
    .DEAD_CYC   (DEAD_CYC),
    .MINOFF_CYC (MINOFF_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .ovp_active (ovp_active),
    .uvp_fault  (uvp_fault),
    .dem_en     (dem_en),
    .zero_cross (zero_cross),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate)
);

// File: tb/cot_gate_seq_test.sv
`timescale 1ns/1ps
module cot_gate_seq_test;
    localparam int TW = 8;
    localparam int DT = 4;
    localparam int MO = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          fb_low = 1'b0;
    logic          ilim_over = 1'b0;
    logic          zero_cross = 1'b0;
    logic          ovp_active = 1'b0;
    logic          uvp_fault = 1'b0;
    logic          dem_en = 1'b1;
    logic [TW-1:0] ton_count = TW'(10);
    logic          hs_gate, ls_gate;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    cot_gate_seq #(.TON_W(TW), .DEAD_CYC(DT), .MINOFF_CYC(MO)) uut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .fb_low     (fb_low),
        .ilim_over  (ilim_over),
        .zero_cross (zero_cross),
        .ovp_active (ovp_active),
        .uvp_fault  (uvp_fault),
        .dem_en     (dem_en),
        .ton_count  (ton_count),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_gate(input bit high_side, input bit v, input int lim, input string req);
        int n = 0;
        while ((((high_side ? hs_gate : ls_gate)) !== v) && (n < lim)) begin
            step(1);
            n++;
        end
        check((high_side ? hs_gate : ls_gate) === v, req, int'(high_side ? hs_gate : ls_gate), int'(v));
    endtask

    // Edge-indexed history of ton_count and event counters, sampled at the active edge.
    int            cyc = 0;
    logic [TW-1:0] hist [64];
    int            fault_ev = 0;
    int            drop_ev  = 0;

    always @(posedge clk) begin
        hist[cyc % 64] <= ton_count;
        cyc <= cyc + 1;
        if (!rst && (ovp_active || uvp_fault || !enable)) fault_ev <= fault_ev + 1;
        if (!rst && !enable) drop_ev <= drop_ev + 1;
    end

    // Continuous monitor on the falling edge.
    logic hs_d = 1'b0, ls_d = 1'b0;
    int   hs_lo = 1000, ls_lo = 1000, hs_w = 0, exp_w = 0;
    int   fault_snap = 0, drop_snap = 0, rises = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(!(hs_gate && ls_gate), "R1 gate overlap", int'(hs_gate && ls_gate), 0);
            if (hs_gate && !hs_d) begin
                check(ls_lo >= DT, "R2 dead time before high side", ls_lo, DT);
                if (drop_ev == drop_snap)
                    check(hs_lo >= MO, "R5 minimum off-time", hs_lo, MO);
                exp_w      = exp_width(int'(hist[(cyc - 1 - DT) % 64]));
                fault_snap = fault_ev;
                hs_w       = 0;
                rises++;
            end
            if (ls_gate && !ls_d)
                check(hs_lo >= DT, "R2 dead time before low side", hs_lo, DT);
            if (!hs_gate && hs_d) begin
                if (fault_ev == fault_snap)
                    check(hs_w == exp_w, "R4 on-time width", hs_w, exp_w);
                drop_snap = drop_ev;
            end
            hs_w  = hs_w + int'(hs_gate);
            hs_lo = hs_gate ? 0 : hs_lo + 1;
            ls_lo = ls_gate ? 0 : ls_lo + 1;
            hs_d  = hs_gate;
            ls_d  = ls_gate;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        int cnt;
        int w;
        int base_rises;
        seed = $urandom(32'd2024);

        // R11 reset state
        enable = 1'b1;
        step(5);
        check(!hs_gate && !ls_gate, "R11 reset holds gates off", int'({hs_gate, ls_gate}), 0);
        rst = 1'b0;
        step(3);
        check(!hs_gate && !ls_gate, "R3 no start without demand", int'({hs_gate, ls_gate}), 0);

        // R3 start latency
        fb_low = 1'b1;
        for (int k = 1; k <= DT + 1; k++) begin
            step(1);
            if (k <= DT) check(hs_gate == 1'b0, "R3 high side early", int'(hs_gate), 0);
            else         check(hs_gate == 1'b1, "R3 high side after dead time", int'(hs_gate), 1);
        end
        fb_low = 1'b0;
        wait_gate(1'b0, 1'b1, 40, "R2 low side follows pulse");

        // R7 diode emulation cutoff
        zero_cross = 1'b1;
        step(1);
        check(ls_gate == 1'b0, "R7 zero-cross opens low side", int'(ls_gate), 0);
        zero_cross = 1'b0;
        step(1);
        check(!ls_gate && !hs_gate, "R7 stays idle", int'({hs_gate, ls_gate}), 0);

        // R7 forced continuous ignores zero crossing
        step(MO);
        fb_low = 1'b1;
        wait_gate(1'b1, 1'b1, 20, "R3 pulse for continuous test");
        fb_low = 1'b0;
        dem_en = 1'b0;
        wait_gate(1'b0, 1'b1, 60, "R7 low side on before test");
        zero_cross = 1'b1;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            step(1);
            if (!ls_gate) cnt++;
        end
        check(cnt == 0, "R7 zero-cross ignored with emulation off", cnt, 0);
        zero_cross = 1'b0;
        dem_en = 1'b1;

        // R6 valley current inhibit
        step(MO + 5);
        ilim_over = 1'b1;
        fb_low = 1'b1;
        cnt = 0;
        for (int k = 0; k < 150; k++) begin
            step(1);
            if (hs_gate) cnt++;
        end
        check(cnt == 0, "R6 no start over current limit", cnt, 0);
        ilim_over = 1'b0;
        step(DT);
        check(hs_gate == 1'b0, "R6 release not early", int'(hs_gate), 0);
        step(1);
        check(hs_gate == 1'b1, "R6 start after release", int'(hs_gate), 1);
        fb_low = 1'b0;

        // R4 on-time captured at start
        wait_gate(1'b0, 1'b1, 300, "R4 low side before capture test");
        step(MO + 5);
        ton_count = TW'(20);
        fb_low = 1'b1;
        step(1);
        ton_count = TW'(3);
        fb_low = 1'b0;
        wait_gate(1'b1, 1'b1, 20, "R4 pulse starts");
        w = 0;
        while (hs_gate && w < 300) begin
            w++;
            step(1);
        end
        check(w == 20, "R4 width taken at start edge", w, 20);

        step(MO + DT + 5);
        ton_count = TW'(0);
        fb_low = 1'b1;
        step(1);
        fb_low = 1'b0;
        wait_gate(1'b1, 1'b1, 20, "R4 zero-count pulse starts");
        w = 0;
        while (hs_gate && w < 300) begin
            w++;
            step(1);
        end
        check(w == 1, "R4 zero count gives one cycle", w, 1);
        ton_count = TW'(10);

        // R8 overvoltage clamp and R9 priority
        step(MO + DT + 5);
        ton_count = TW'(30);
        fb_low = 1'b1;
        step(1);
        fb_low = 1'b0;
        wait_gate(1'b1, 1'b1, 20, "R8 pulse before overvoltage");
        step(3);
        ovp_active = 1'b1;
        step(1);
        check(hs_gate == 1'b0, "R8 high side cut", int'(hs_gate), 0);
        step(DT - 1);
        check(ls_gate == 1'b0, "R8 clamp waits dead time", int'(ls_gate), 0);
        step(1);
        check(ls_gate == 1'b1, "R8 clamp engages", int'(ls_gate), 1);
        fb_low = 1'b1;
        uvp_fault = 1'b1;
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            step(1);
            if (hs_gate || !ls_gate) cnt++;
        end
        check(cnt == 0, "R9 overvoltage wins over undervoltage", cnt, 0);
        ovp_active = 1'b0;
        step(1);
        check(!hs_gate && !ls_gate, "R9 undervoltage opens both", int'({hs_gate, ls_gate}), 0);
        uvp_fault = 1'b0;
        fb_low = 1'b0;

        // R9 undervoltage during on-time
        step(MO + DT + 5);
        fb_low = 1'b1;
        step(1);
        fb_low = 1'b0;
        wait_gate(1'b1, 1'b1, 20, "R9 pulse before undervoltage");
        step(3);
        uvp_fault = 1'b1;
        step(1);
        check(!hs_gate && !ls_gate, "R9 undervoltage opens both", int'({hs_gate, ls_gate}), 0);
        fb_low = 1'b1;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (hs_gate || ls_gate) cnt++;
        end
        check(cnt == 0, "R9 held off during undervoltage", cnt, 0);
        uvp_fault = 1'b0;
        fb_low = 1'b0;

        // R10 enable low clears timers
        step(MO + DT + 5);
        fb_low = 1'b1;
        step(1);
        fb_low = 1'b0;
        wait_gate(1'b1, 1'b1, 20, "R10 pulse before disable");
        step(2);
        enable = 1'b0;
        step(1);
        check(!hs_gate && !ls_gate, "R10 disable opens both", int'({hs_gate, ls_gate}), 0);
        step(3);
        enable = 1'b1;
        fb_low = 1'b1;
        step(DT);
        check(hs_gate == 1'b0, "R10 restart not early", int'(hs_gate), 0);
        step(1);
        check(hs_gate == 1'b1, "R10 restart ignores old off-time", int'(hs_gate), 1);
        fb_low = 1'b0;

        // Constrained random mix
        step(MO + 2 * DT + 40);
        base_rises = rises;
        for (int k = 0; k < 4000; k++) begin
            step(1);
            fb_low     = ($urandom_range(0, 99) < 40);
            ilim_over  = ($urandom_range(0, 99) < 8);
            zero_cross = ($urandom_range(0, 99) < 15);
            if ($urandom_range(0, 499) == 0) dem_en = ~dem_en;
            if ($urandom_range(0, 3) == 0) ton_count = TW'($urandom_range(0, 47));
            if (!ovp_active && $urandom_range(0, 599) == 0) ovp_active = 1'b1;
            else if (ovp_active && $urandom_range(0, 29) == 0) ovp_active = 1'b0;
            if (!uvp_fault && $urandom_range(0, 599) == 0) uvp_fault = 1'b1;
            else if (uvp_fault && $urandom_range(0, 19) == 0) uvp_fault = 1'b0;
            if (enable && $urandom_range(0, 799) == 0) enable = 1'b0;
            else if (!enable && $urandom_range(0, 9) == 0) enable = 1'b1;
        end
        check((rises - base_rises) > 20, "R3 random traffic starts cycles", rises - base_rises, 21);

        fb_low = 1'b0;
        ovp_active = 1'b0;
        uvp_fault = 1'b0;
        enable = 1'b1;
        step(5);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule